// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside the CPU of a small 8-bit microcontroller. It makes the synchronous core reset and decides which clocks run. The external reset pin does not reset the core at once. The pin must stay high for a whole number of machine cycles before the reset is accepted. Each machine cycle is a fixed number of oscillator clocks. While the pin is high, and for as long as the core reset lasts, all port outputs are forced to 1.

Software can ask for two low-power modes. In idle, only the CPU clock stops. Timers, the serial port and the interrupt logic keep running, and either a pending enabled interrupt or a hardware reset brings the CPU back. In power-down, the oscillator and every clock stop. Only a hardware reset ends power-down. The reset pin turns the oscillator back on as soon as it is seen high, so that the qualification counter can run.

A supply brown-out flag holds the core in reset and weakly pulls up every port pin except the two analog comparator inputs. When the flag clears, the reset stays asserted for a programmable number of oscillator clocks. A new brown-out during that delay starts the delay again. The reset clears the special function registers only. The on-chip RAM is kept outside this reset domain, so its contents survive a reset.

Top module: `pmc_top`

## Requirements
- R1: While `por_n` is low, `core_rst_n` is 0, `port_force_high` is 1, `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, and `port_weak_high` is all zeros.
- R2: A core reset is produced only when `reset_pin` stays high for at least MC_CLKS*MC_COUNT consecutive oscillator clocks (24 with 12 clocks per machine cycle and 2 cycles). A high pulse one clock shorter produces no reset.
- R3: `port_force_high` rises within 3 clocks after `reset_pin` rises, before the qualification completes. It stays 1 while the core reset is asserted.
- R4: Once qualified, the core reset lasts while the pin stays high. `core_rst_n` returns to 1 within 4 clocks after the pin falls, provided there is no brown-out.
- R5: In run mode, an `idle_req` clears `cpu_clk_en` on the next clock. `periph_clk_en` and `osc_en` stay 1.
- R6: Idle mode ends in run mode either when `irq_pending` is high, one clock later, or through a qualified pin reset. A pin pulse that is still being qualified leaves idle in place. `irq_pending` has no effect in run mode.
- R7: In run mode, a `pdown_req` clears `cpu_clk_en`, `periph_clk_en` and `osc_en`. When both requests are high together, power-down is chosen. `irq_pending` does not end power-down.
- R8: In power-down, `osc_en` returns to 1 within 3 clocks after `reset_pin` rises. A qualified pin reset then returns the block to run mode.
- R9: While `brownout` is high, `core_rst_n` is 0 and `port_weak_high` drives 1 on every bit whose `EXEMPT_MASK` bit is 0. Bits 0 and 1 are exempt by default, so the value is 16'hFFFC for 16 pins. Otherwise `port_weak_high` is 0.
- R10: After `brownout` falls, `core_rst_n` stays 0 through the first BO_DELAY+2 rising clock edges. It becomes 1 after edge BO_DELAY+3.
- R11: A brown-out that arrives during the recovery delay restarts the delay from its full length.
- R12: `idle_req` and `pdown_req` are ignored while the core reset is asserted. After release the block is in run mode with all clocks enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Synchronous active-low power-on reset of this block |
| reset_pin | input | 1 | External reset pin, asynchronous, active high |
| brownout | input | 1 | Brown-out comparator flag, asynchronous, active high |
| idle_req | input | 1 | Software request to enter idle |
| pdown_req | input | 1 | Software request to enter power-down |
| irq_pending | input | 1 | An enabled interrupt is pending |
| core_rst_n | output | 1 | Synchronous active-low reset for the CPU and special registers |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral (timer, serial, interrupt) clock enable |
| osc_en | output | 1 | Oscillator enable |
| port_force_high | output | 1 | Force all port outputs to 1 |
| port_weak_high | output | PORT_BITS | Per-pin weak pull-up enable during brown-out |

## Verification
The bench keeps the default machine cycle of 12 clocks and 2 qualifying cycles, so the 23- and 24-clock pin pulses sit exactly on the qualification boundary. It sets BO_DELAY to 40 clocks in place of the default of about 15 ms. This puts the exact release edge after a brown-out, and the restart of the delay, within a few hundred cycles. PORT_BITS stays at 16 with the two low pins exempt, so the weak pull pattern shows both exempt and driven bits.

// File: rtl/pmc_pkg.sv
// Package: shared types of the reset and power-mode controller.
// Assumes: none; it holds only types.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2
    } pm_mode_t;
endpackage

// File: rtl/pmc_sync2.sv
// Two-flop synchroniser for asynchronous level inputs.
// Assumes: each input is a level that is held for several clock periods.
module pmc_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pmc_pin_qual.sv
// Reset pin qualifier: it counts machine cycles while the synchronised pin is
// high. It raises 'qualified' after MC_COUNT full machine cycles of
// MC_CLKS clocks each, and lowers it as soon as the pin is seen low.
// Assumes: MC_CLKS >= 2 and MC_COUNT >= 1; pin_s is already synchronised.
module pmc_pin_qual #(
    parameter int MC_CLKS  = 12,
    parameter int MC_COUNT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    output logic qualified
);
    localparam int PW = $clog2(MC_CLKS);
    localparam int CW = $clog2(MC_COUNT + 1);

    logic [PW-1:0] phase;
    logic [CW-1:0] mcycles;

    // Count the clock phase and the machine cycles of a continuous high level.
    always_ff @(posedge clk) begin
        if (!rst_n || !pin_s) begin
            phase     <= '0;
            mcycles   <= '0;
            qualified <= 1'b0;
        end else if (phase == PW'(MC_CLKS - 1)) begin
            phase <= '0;
            if (!qualified) begin
                mcycles <= mcycles + 1'b1;
            end
            if (mcycles == CW'(MC_COUNT - 1)) begin
                qualified <= 1'b1;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R2: the reset is qualified only when the pin was high the cycle before.
    a_r2_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(pin_s));

    // R4: when the pin is seen low, the qualified reset drops.
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_s |=> !qualified);
endmodule

// File: rtl/pmc_bo_timer.sv
// Brown-out recovery timer: it holds the reset while the flag is high, then
// for BO_DELAY more clocks. A new flag during the delay reloads the count.
// Assumes: bo_s is already synchronised and BO_DELAY >= 1.
module pmc_bo_timer #(
    parameter int BO_DELAY = 180000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bo_s,
    output logic bo_rst
);
    localparam int CW = $clog2(BO_DELAY + 1);

    logic [CW-1:0] remain;

    // Load the count while in brown-out and count it down afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (bo_s) begin
            remain <= CW'(BO_DELAY);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Hold the reset during brown-out and for the rest of the delay.
    always_comb begin
        bo_rst = bo_s || (remain != '0);
    end

    // R10: with the flag low, the remaining delay never grows.
    a_r10_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (!bo_s && $past(!bo_s)) |-> (remain <= $past(remain)));

    // R11: a brown-out during the delay brings back the full count.
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        bo_s |=> (remain == CW'(BO_DELAY)));
endmodule

// File: rtl/pmc_mode_fsm.sv
// Power-mode state machine: run, idle and power-down.
// Assumes: 'hold' is high for any hardware reset. The requests are sampled
// only in run mode, and power-down wins over idle.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hold,
    input  logic     idle_req,
    input  logic     pdown_req,
    input  logic     irq_pending,
    output pm_mode_t mode
);
    pm_mode_t mode_nx;

    // Pick the next mode from the requests and the exit conditions.
    always_comb begin
        mode_nx = mode;
        if (hold) begin
            mode_nx = PM_RUN;
        end else begin
            unique case (mode)
                PM_RUN: begin
                    if (pdown_req)     mode_nx = PM_PDOWN;
                    else if (idle_req) mode_nx = PM_IDLE;
                end
                PM_IDLE: begin
                    if (irq_pending) mode_nx = PM_RUN;
                end
                PM_PDOWN: mode_nx = PM_PDOWN;
                default:  mode_nx = PM_RUN;
            endcase
        end
    end

    // Register the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= PM_RUN;
        else        mode <= mode_nx;
    end

    // R7: only a hardware reset ends power-down.
    a_r7_pdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PDOWN && !hold) |=> (mode == PM_PDOWN));

    // R6: a pending interrupt ends idle.
    a_r6_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_IDLE && irq_pending) |=> (mode == PM_RUN));

    // R12: while a reset is held, the mode is run.
    a_r12_run_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (mode == PM_RUN));
endmodule

// File: rtl/pmc_top.sv
// Reset and power-mode controller top. It synchronises the reset pin and the
// brown-out flag, qualifies the pin in machine cycles, times the brown-out
// recovery, and drives the reset, the clock enables and the port controls.
// Assumes: clk_osc keeps running in the model even while osc_en is low.
module pmc_top #(
    parameter int                 MC_CLKS     = 12,
    parameter int                 MC_COUNT    = 2,
    parameter int                 BO_DELAY    = 180000,
    parameter int                 PORT_BITS   = 16,
    parameter logic [PORT_BITS-1:0] EXEMPT_MASK = PORT_BITS'(3)
) (
    input  logic                 clk_osc,
    input  logic                 por_n,
    input  logic                 reset_pin,
    input  logic                 brownout,
    input  logic                 idle_req,
    input  logic                 pdown_req,
    input  logic                 irq_pending,
    output logic                 core_rst_n,
    output logic                 cpu_clk_en,
    output logic                 periph_clk_en,
    output logic                 osc_en,
    output logic                 port_force_high,
    output logic [PORT_BITS-1:0] port_weak_high
);
    import pmc_pkg::*;

    logic [1:0] sync_q;
    logic       pin_s;
    logic       bo_s;
    logic       pin_rst;
    logic       bo_rst;
    logic       rst_any;
    pm_mode_t   mode;

    pmc_sync2 #(.WIDTH(2)) i_sync (
        .clk   (clk_osc),
        .rst_n (por_n),
        .d     ({brownout, reset_pin}),
        .q     (sync_q)
    );

    assign pin_s = sync_q[0];
    assign bo_s  = sync_q[1];

    pmc_pin_qual #(.MC_CLKS(MC_CLKS), .MC_COUNT(MC_COUNT)) i_qual (
        .clk       (clk_osc),
        .rst_n     (por_n),
        .pin_s     (pin_s),
        .qualified (pin_rst)
    );

    pmc_bo_timer #(.BO_DELAY(BO_DELAY)) i_bo (
        .clk    (clk_osc),
        .rst_n  (por_n),
        .bo_s   (bo_s),
        .bo_rst (bo_rst)
    );

    assign rst_any = pin_rst || bo_rst;

    pmc_mode_fsm i_fsm (
        .clk         (clk_osc),
        .rst_n       (por_n),
        .hold        (rst_any),
        .idle_req    (idle_req),
        .pdown_req   (pdown_req),
        .irq_pending (irq_pending),
        .mode        (mode)
    );

    // Register the core reset and the port force-high control.
    always_ff @(posedge clk_osc) begin
        if (!por_n) begin
            core_rst_n      <= 1'b0;
            port_force_high <= 1'b1;
        end else begin
            core_rst_n      <= !rst_any;
            port_force_high <= pin_s || rst_any;
        end
    end

    // Derive the clock enables from the mode; the pin wakes the oscillator.
    always_comb begin
        cpu_clk_en    = (mode == PM_RUN);
        periph_clk_en = (mode != PM_PDOWN);
        osc_en        = (mode != PM_PDOWN) || pin_s;
    end

    // One weak pull-up per port bit; the exempt bits are tied off.
    for (genvar gi = 0; gi < PORT_BITS; gi++) begin : g_weak
        if (EXEMPT_MASK[gi]) begin : g_exempt
            assign port_weak_high[gi] = 1'b0;
        end else begin : g_pull
            always_ff @(posedge clk_osc) begin
                if (!por_n) port_weak_high[gi] <= 1'b0;
                else        port_weak_high[gi] <= bo_s;
            end
        end
    end

    // R3: the force-high control follows the pin before qualification.
    a_r3_force_on_pin: assert property (@(posedge clk_osc) disable iff (!por_n)
        pin_s |=> port_force_high);

    // R9: a brown-out always holds the core in reset.
    a_r9_bo_reset: assert property (@(posedge clk_osc) disable iff (!por_n)
        bo_s |=> !core_rst_n);

    // R8: in power-down, a high pin keeps the oscillator on.
    a_r8_osc_wake: assert property (@(posedge clk_osc) disable iff (!por_n)
        (pin_s && !periph_clk_en) |-> osc_en);
endmodule

// File: tb/test_pmc_top.sv
`timescale 1ns/1ps
module test_pmc_top;
    localparam int BO_D = 40;

    logic        clk_osc = 1'b0;
    logic        por_n = 1'b0;
    logic        reset_pin = 1'b0;
    logic        brownout = 1'b0;
    logic        idle_req = 1'b0;
    logic        pdown_req = 1'b0;
    logic        irq_pending = 1'b0;
    logic        core_rst_n;
    logic        cpu_clk_en;
    logic        periph_clk_en;
    logic        osc_en;
    logic        port_force_high;
    logic [15:0] port_weak_high;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk_osc = ~clk_osc;

    pmc_top #(.BO_DELAY(BO_D)) i_pmc_top (
        .clk_osc(clk_osc), .por_n(por_n), .reset_pin(reset_pin),
        .brownout(brownout), .idle_req(idle_req), .pdown_req(pdown_req),
        .irq_pending(irq_pending), .core_rst_n(core_rst_n),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_en(osc_en), .port_force_high(port_force_high),
        .port_weak_high(port_weak_high)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk_osc);
        @(negedge clk_osc);
    endtask

    task automatic pin_hold(input int n);
        reset_pin = 1'b1;
        clks(n);
        reset_pin = 1'b0;
    endtask

    // R1: values while the power-on reset is held.
    task automatic t_reset_state();
        clks(3);
        chk("R1 core_rst_n", core_rst_n, 0);
        chk("R1 force_high", port_force_high, 1);
        chk("R1 clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
        chk("R1 weak", port_weak_high, 0);
        por_n = 1'b1;
        clks(3);
        chk("R1 release core_rst_n", core_rst_n, 1);
        chk("R1 release force_high", port_force_high, 0);
    endtask

    // R2 and R3: pulse lengths at the qualification boundary.
    task automatic t_pin_pulse(input int len, input bit expect_rst);
        int lows = 0;
        bit force_seen = 0;
        reset_pin = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(posedge clk_osc); @(negedge clk_osc);
            if (port_force_high && core_rst_n) force_seen = 1;
            if (i == 2) chk("R3 force within 3 clocks", port_force_high, 1);
            if (!core_rst_n) lows++;
        end
        reset_pin = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk_osc); @(negedge clk_osc);
            if (!core_rst_n) begin
                lows++;
                chk("R3 force during reset", port_force_high, 1);
            end
        end
        chk("R3 force before reset", force_seen, 1);
        chk($sformatf("R2 pulse %0d", len), lows != 0, expect_rst);
        chk("R4 released", core_rst_n, 1);
    endtask

    // R4: a long qualified reset lasts while the pin is high.
    task automatic t_pin_long();
        reset_pin = 1'b1;
        clks(40);
        chk("R4 held", core_rst_n, 0);
        reset_pin = 1'b0;
        clks(4);
        chk("R4 release within 4", core_rst_n, 1);
    endtask

    // R5 and R6: idle entry, interrupt exit, pin-reset exit.
    task automatic t_idle();
        irq_pending = 1'b1;
        clks(2);
        chk("R6 irq in run no effect", cpu_clk_en, 1);
        irq_pending = 1'b0;
        idle_req = 1'b1;
        clks(1);
        idle_req = 1'b0;
        chk("R5 cpu stopped", cpu_clk_en, 0);
        chk("R5 periph and osc on", {periph_clk_en, osc_en}, 2'b11);
        clks(5);
        chk("R5 idle stays", cpu_clk_en, 0);
        irq_pending = 1'b1;
        clks(1);
        irq_pending = 1'b0;
        chk("R6 irq wakes", cpu_clk_en, 1);
        idle_req = 1'b1;
        clks(1);
        idle_req = 1'b0;
        reset_pin = 1'b1;
        clks(10);
        chk("R6 idle during qualification", cpu_clk_en, 0);
        clks(20);
        chk("R6 reset asserted", core_rst_n, 0);
        chk("R6 reset ends idle", cpu_clk_en, 1);
        reset_pin = 1'b0;
        clks(5);
    endtask

    // R7 and R8: power-down entry, stickiness, wake by pin.
    task automatic t_pdown();
        idle_req = 1'b1;
        pdown_req = 1'b1;
        clks(1);
        idle_req = 1'b0;
        pdown_req = 1'b0;
        chk("R7 pdown priority clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b000);
        irq_pending = 1'b1;
        clks(5);
        irq_pending = 1'b0;
        chk("R7 irq ignored", osc_en, 0);
        reset_pin = 1'b1;
        clks(3);
        chk("R8 osc wakes", osc_en, 1);
        chk("R8 cpu still off", cpu_clk_en, 0);
        clks(30);
        chk("R8 reset", core_rst_n, 0);
        chk("R8 run mode", {cpu_clk_en, periph_clk_en}, 2'b11);
        reset_pin = 1'b0;
        clks(5);
        chk("R8 released", core_rst_n, 1);
    endtask

    // R9 and R10: brown-out hold, weak pulls, exact release edge.
    task automatic t_brownout();
        brownout = 1'b1;
        clks(10);
        chk("R9 reset held", core_rst_n, 0);
        chk("R9 weak mask", port_weak_high, 16'hFFFC);
        brownout = 1'b0;
        clks(BO_D + 2);
        chk("R10 still in reset", core_rst_n, 0);
        chk("R9 weak off", port_weak_high, 0);
        clks(1);
        chk("R10 released", core_rst_n, 1);
    endtask

    // R11: a brown-out inside the delay restarts it.
    task automatic t_bo_restart();
        brownout = 1'b1;
        clks(6);
        brownout = 1'b0;
        clks(20);
        brownout = 1'b1;
        clks(3);
        brownout = 1'b0;
        clks(BO_D + 2);
        chk("R11 restart held", core_rst_n, 0);
        clks(1);
        chk("R11 restart released", core_rst_n, 1);
    endtask

    // R12: requests during reset are ignored.
    task automatic t_req_in_reset();
        reset_pin = 1'b1;
        clks(30);
        idle_req = 1'b1;
        pdown_req = 1'b1;
        clks(3);
        idle_req = 1'b0;
        pdown_req = 1'b0;
        chk("R12 clocks in reset", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
        reset_pin = 1'b0;
        clks(6);
        chk("R12 after release", {core_rst_n, cpu_clk_en, periph_clk_en, osc_en}, 4'b1111);
    endtask

    initial begin
        t_reset_state();
        t_pin_pulse(23, 1'b0);
        t_pin_pulse(24, 1'b1);
        t_pin_long();
        t_idle();
        t_pdown();
        t_brownout();
        t_bo_restart();
        t_req_in_reset();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_osc);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule